// File: doc/BRIEF.md
# Flash Page Erase Sequencer

This block runs the high-voltage erase of a single 64-byte page of an on-chip flash array. Software first writes a small control register to select erase on its own, with program and whole-array erase off. It then writes any data to any address inside the page to be cleared. That write latches the page base and starts a timed sequence. The sequence drives the array's erase-select and high-voltage-enable lines in a fixed order: a setup wait, the erase pulse, a hold wait with erase dropped, and a recovery wait after high voltage is removed. All waits are counted in clock cycles, derived from a clock-frequency parameter and a divider that lets simulation shorten them.

A protect input, decoded outside from the latched page base, is sampled at the end of the setup wait. A locked page aborts the sequence before high voltage is ever applied, and an error flag is raised. While the sequence runs, the block refuses further erase requests, control register writes and array reads. The top 64-byte page holds the interrupt vectors and the oscillator trim bytes at 0xFFC0 and 0xFFC1. Erasing it raises a trim-clear line for the duration of the erase pulse.

Top module: `page_erase_seq`

## Requirements
- R1: After reset the control register reads 0, busy, errFlag, eraseOut, hvenOut and trimClr are 0, and pageBase is 0.
- R2: regRdData bit 0 is erase-select, bit 1 is program-select, bit 2 is whole-array select, and bit 3 is the read-only high-voltage state. A register write of regWrData (bits 2:0 in the same order) that has both bit 0 and bit 1 at 1 is rejected, and all previous bits are kept. Erase-select and program-select are never both 1.
- R3: A memory write while idle, with erase-select 1, program-select 0 and whole-array select 0, latches pageBase as the write address with its low 6 bits cleared, and raises busy in the next cycle. Any other memory write starts nothing and leaves pageBase unchanged.
- R4: After busy rises, hvenOut stays 0 and eraseOut stays 1 for T_SETUP cycles (at least 10 µs). hvenOut then rises while eraseOut is still 1.
- R5: hvenOut and eraseOut are both 1 for T_ERASE cycles (1 ms) when longMode is 0, or for T_LONG cycles (4 ms) when longMode is 1.
- R6: eraseOut falls first. hvenOut then stays 1 for T_HOLD cycles (at least 5 µs) before it falls.
- R7: After hvenOut falls, busy stays 1 for T_REC cycles (about 1 µs) and then falls. After a completed erase, erase-select reads 0 and errFlag is 0.
- R8: If pageLocked is 1 at the end of the setup wait, hvenOut never rises. In the same edge erase-select clears, busy falls and errFlag rises. errFlag clears on the next accepted register write or page latch.
- R9: While busy, memory writes do not relatch pageBase, register writes have no effect, and memRdGrant is 0. While idle, memRdGrant equals memRdReq.
- R10: trimClr is 1 exactly during the erase pulse of a page whose address bits 15:6 are all 1, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 3 | Write data: erase, program, whole-array select |
| regRdData | output | 4 | Register readback including high-voltage state |
| memWrEn | input | 1 | Write into the flash address space |
| memAddr | input | 16 | Address of that write |
| memRdReq | input | 1 | Array read request |
| memRdGrant | output | 1 | Read allowed this cycle |
| longMode | input | 1 | Selects the 4 ms erase pulse |
| pageLocked | input | 1 | Protect status of the latched page |
| eraseOut | output | 1 | Erase select to the array |
| hvenOut | output | 1 | High-voltage enable to the array |
| trimClr | output | 1 | Trim bytes are being erased |
| busy | output | 1 | Sequence in progress |
| errFlag | output | 1 | Last erase aborted on a locked page |
| pageBase | output | 16 | Latched page base address |

## Verification
Register readback, pageBase and busy are due one cycle after the write that changes them. The bench drives inputs on the falling edge and reads results on the next falling edge, which is the first point at which they can have changed. The phase intervals are measured by sampling eraseOut, hvenOut and busy on every falling edge while busy is high. Each phase is classified, its cycles are counted, and a phase that appears out of order is flagged. The counts are then compared with bench-computed cycle figures for setup, erase (both modes), hold and recovery. memRdGrant is combinational and is checked in every sampled busy cycle and once idle.

// File: rtl/pes_pkg.sv
package pes_pkg;

  typedef struct packed {
    logic latchPage;
    logic clrErase;
    logic setErr;
  } pesStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ERASE,
    ST_HOLD,
    ST_RECOV
  } pesState_t;

  // Cycles for a wait of 'us' microseconds at 'mhz', divided by 'div', rounded up, at least 1.
  function automatic int unsigned usToCycles(int unsigned mhz, int unsigned us, int unsigned div);
    int unsigned t;
    t = (mhz * us + div - 1) / div;
    return (t == 0) ? 1 : t;
  endfunction

endpackage

// File: rtl/pes_ctrl.sv
module pes_ctrl
  import pes_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned TIME_DIV = 1,
  parameter int unsigned SETUP_US = 10,
  parameter int unsigned ERASE_US = 1000,
  parameter int unsigned LONG_US  = 4000,
  parameter int unsigned HOLD_US  = 5,
  parameter int unsigned REC_US   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       pageLocked,
  input  logic       longMode,
  output pesStrobe_t strobe,
  output logic       busyOut,
  output logic       hvenOut
);

  localparam int unsigned T_SETUP = usToCycles(CLK_MHZ, SETUP_US, TIME_DIV);
  localparam int unsigned T_ERASE = usToCycles(CLK_MHZ, ERASE_US, TIME_DIV);
  localparam int unsigned T_LONG  = usToCycles(CLK_MHZ, LONG_US, TIME_DIV);
  localparam int unsigned T_HOLD  = usToCycles(CLK_MHZ, HOLD_US, TIME_DIV);
  localparam int unsigned T_REC   = usToCycles(CLK_MHZ, REC_US, TIME_DIV);
  localparam int unsigned T_MAX   = (T_LONG > T_ERASE) ? T_LONG : T_ERASE;
  localparam int          CNT_W   = $clog2(T_MAX + 1);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(T_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_ERASE = CNT_W'(T_ERASE - 1);
  localparam logic [CNT_W-1:0] LD_LONG  = CNT_W'(T_LONG - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(T_HOLD - 1);
  localparam logic [CNT_W-1:0] LD_REC   = CNT_W'(T_REC - 1);

  pesState_t        state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic             cntDone;

  assign cntDone = (cnt == '0);

  always_comb begin
    strobe = '0;
    nState = state;
    nCnt   = cntDone ? cnt : cnt - 1'b1;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.latchPage = 1'b1;
          nState           = ST_SETUP;
          nCnt             = LD_SETUP;
        end
      end
      ST_SETUP: begin
        if (cntDone) begin
          if (pageLocked) begin
            strobe.clrErase = 1'b1;
            strobe.setErr   = 1'b1;
            nState          = ST_IDLE;
          end else begin
            nState = ST_ERASE;
            nCnt   = longMode ? LD_LONG : LD_ERASE;
          end
        end
      end
      ST_ERASE: begin
        if (cntDone) begin
          strobe.clrErase = 1'b1;
          nState          = ST_HOLD;
          nCnt            = LD_HOLD;
        end
      end
      ST_HOLD: begin
        if (cntDone) begin
          nState = ST_RECOV;
          nCnt   = LD_REC;
        end
      end
      ST_RECOV: begin
        if (cntDone) nState = ST_IDLE;
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nState;
      cnt   <= nCnt;
    end
  end

  assign busyOut = (state != ST_IDLE);
  assign hvenOut = (state == ST_ERASE) || (state == ST_HOLD);

  // R8
  locked_no_hv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP && cntDone && pageLocked) |=> !hvenOut && !busyOut);

  // R3
  idle_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOut && startReq) |=> busyOut && !hvenOut);

endmodule

// File: rtl/pes_datapath.sv
module pes_datapath
  import pes_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  pesStrobe_t        strobe,
  input  logic              busyIn,
  input  logic              hvenIn,
  input  logic              regWrEn,
  input  logic [2:0]        regWrData,
  input  logic              memWrEn,
  input  logic [ADDR_W-1:0] memAddr,
  output logic              startReq,
  output logic              eraseSel,
  output logic [3:0]        regRdData,
  output logic [ADDR_W-1:0] pageBase,
  output logic              errFlag,
  output logic              vecPage
);

  localparam int               PAGE_BITS = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);

  logic pgmSel, massSel, regAccept;

  assign regAccept = regWrEn && !busyIn && !(regWrData[0] && regWrData[1]);
  assign startReq  = memWrEn && !busyIn && eraseSel && !pgmSel && !massSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseSel <= 1'b0;
      pgmSel   <= 1'b0;
      massSel  <= 1'b0;
    end else if (regAccept) begin
      eraseSel <= regWrData[0];
      pgmSel   <= regWrData[1];
      massSel  <= regWrData[2];
    end else if (strobe.clrErase) begin
      eraseSel <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (strobe.setErr) begin
      errFlag <= 1'b1;
    end else if (regAccept || strobe.latchPage) begin
      errFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageBase <= '0;
    else if (strobe.latchPage) pageBase <= memAddr & ~PAGE_MASK;
  end

  assign vecPage   = &pageBase[ADDR_W-1:PAGE_BITS];
  assign regRdData = {hvenIn, massSel, pgmSel, eraseSel};

  // R2
  interlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(eraseSel && pgmSel));

  // R3
  latch_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchPage |-> (eraseSel && !pgmSel && !massSel));

endmodule

// File: rtl/page_erase_seq.sv
module page_erase_seq
  import pes_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          PAGE_BYTES = 64,
  parameter int unsigned CLK_MHZ    = 125,
  parameter int unsigned TIME_DIV   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regWrData,
  output logic [3:0]        regRdData,
  input  logic              memWrEn,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memRdReq,
  output logic              memRdGrant,
  input  logic              longMode,
  input  logic              pageLocked,
  output logic              eraseOut,
  output logic              hvenOut,
  output logic              trimClr,
  output logic              busy,
  output logic              errFlag,
  output logic [ADDR_W-1:0] pageBase
);

  pesStrobe_t strobe;
  logic       startReq, vecPage;

  pes_ctrl #(
    .CLK_MHZ (CLK_MHZ),
    .TIME_DIV(TIME_DIV)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .pageLocked(pageLocked),
    .longMode  (longMode),
    .strobe    (strobe),
    .busyOut   (busy),
    .hvenOut   (hvenOut)
  );

  pes_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busyIn   (busy),
    .hvenIn   (hvenOut),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .memWrEn  (memWrEn),
    .memAddr  (memAddr),
    .startReq (startReq),
    .eraseSel (eraseOut),
    .regRdData(regRdData),
    .pageBase (pageBase),
    .errFlag  (errFlag),
    .vecPage  (vecPage)
  );

  assign trimClr    = hvenOut && eraseOut && vecPage;
  assign memRdGrant = memRdReq && !busy;

  // R4
  hv_after_erase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hvenOut) |-> eraseOut);

  // R6
  erase_before_hv_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hvenOut) |-> !eraseOut);

  // R6
  hold_keeps_hv_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(eraseOut) && busy) |-> hvenOut);

  // R8
  abort_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (!busy && !eraseOut && !hvenOut));

endmodule

// File: tb/page_erase_seq_bench.sv
module page_erase_seq_bench;

  localparam int unsigned MHZ = 125;
  localparam int unsigned DIV = 250;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrData = '0;
  logic [3:0]  regRdData;
  logic        memWrEn = 1'b0;
  logic [15:0] memAddr = '0;
  logic        memRdReq = 1'b0;
  logic        memRdGrant;
  logic        longMode = 1'b0;
  logic        pageLocked = 1'b0;
  logic        eraseOut, hvenOut, trimClr, busy, errFlag;
  logic [15:0] pageBase;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  page_erase_seq #(.CLK_MHZ(MHZ), .TIME_DIV(DIV)) u_page_erase_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .memWrEn(memWrEn), .memAddr(memAddr),
    .memRdReq(memRdReq), .memRdGrant(memRdGrant), .longMode(longMode),
    .pageLocked(pageLocked), .eraseOut(eraseOut), .hvenOut(hvenOut),
    .trimClr(trimClr), .busy(busy), .errFlag(errFlag), .pageBase(pageBase)
  );

  function automatic int cyc(int unsigned us);
    int unsigned t;
    t = (MHZ * us + DIV - 1) / DIV;
    return (t == 0) ? 1 : int'(t);
  endfunction

  function automatic logic [15:0] baseOf(logic [15:0] a);
    return {a[15:6], 6'b0};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic memWrite(logic [15:0] a);
    @(negedge clk);
    memWrEn = 1'b1; memAddr = a;
    @(negedge clk);
    memWrEn = 1'b0;
  endtask

  task automatic runErase(logic [15:0] addr, bit lm, bit lock);
    int setupC, eraseC, holdC, recC, phase, orderBad, grantBad, trimBad, guard;
    logic [15:0] expBase;
    bit expVec;
    expBase = baseOf(addr);
    expVec  = (addr[15:6] == 10'h3FF);
    setupC = 0; eraseC = 0; holdC = 0; recC = 0; phase = 0;
    orderBad = 0; grantBad = 0; trimBad = 0; guard = 0;
    regWrite(3'b001);
    check(regRdData == 4'b0001, "R2 erase select", regRdData, 1);
    memRdReq = 1'b1; longMode = lm; pageLocked = lock;
    memWrite(addr);
    // R3: busy and pageBase one cycle after the write
    check(busy == 1'b1, "R3 busy", busy, 1);
    check(pageBase == expBase, "R3 page base", pageBase, expBase);
    while (busy && guard < 6000) begin
      if (memRdGrant) grantBad++;
      if (trimClr != (expVec && hvenOut && eraseOut)) trimBad++;
      if (!hvenOut && eraseOut) begin
        if (phase > 0) orderBad++;
        setupC++;
      end else if (hvenOut && eraseOut) begin
        if (phase > 1) orderBad++;
        phase = 1; eraseC++;
      end else if (hvenOut && !eraseOut) begin
        if (phase > 2 || phase < 1) orderBad++;
        phase = 2; holdC++;
      end else begin
        if (phase < 2) orderBad++;
        phase = 3; recC++;
      end
      if (guard == 1) begin
        memWrEn = 1'b1; memAddr = addr ^ 16'h4000;
        regWrEn = 1'b1; regWrData = 3'b100;
      end else begin
        memWrEn = 1'b0; regWrEn = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    memWrEn = 1'b0; regWrEn = 1'b0;
    check(setupC == cyc(10), "R4 setup cycles", setupC, cyc(10));
    check(orderBad == 0, "R4 phase order", orderBad, 0);
    if (lock) begin
      check(eraseC + holdC + recC == 0, "R8 no high voltage", eraseC + holdC + recC, 0);
      check(errFlag == 1'b1, "R8 error flag", errFlag, 1);
    end else begin
      check(eraseC == (lm ? cyc(4000) : cyc(1000)), "R5 erase cycles", eraseC,
            lm ? cyc(4000) : cyc(1000));
      check(holdC == cyc(5), "R6 hold cycles", holdC, cyc(5));
      check(recC == cyc(1), "R7 recovery cycles", recC, cyc(1));
      check(errFlag == 1'b0, "R7 no error", errFlag, 0);
    end
    check(regRdData == 4'b0000, "R9 register untouched while busy, erase cleared", regRdData, 0);
    check(pageBase == expBase, "R9 no relatch while busy", pageBase, expBase);
    check(grantBad == 0, "R9 reads refused while busy", grantBad, 0);
    check(memRdGrant == 1'b1, "R9 read granted when idle", memRdGrant, 1);
    check(trimBad == 0, "R10 trim clear", trimBad, 0);
    memRdReq = 1'b0; pageLocked = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(regRdData == 4'b0000, "R1 register", regRdData, 0);
    check(busy == 0 && hvenOut == 0 && eraseOut == 0 && errFlag == 0 && trimClr == 0,
          "R1 outputs", {busy, hvenOut, eraseOut, errFlag, trimClr}, 0);
    check(pageBase == 16'h0, "R1 page base", pageBase, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 interlock
    regWrite(3'b011);
    check(regRdData == 4'b0000, "R2 both rejected from zero", regRdData, 0);
    regWrite(3'b001);
    regWrite(3'b011);
    check(regRdData == 4'b0001, "R2 both rejected keeps erase", regRdData, 1);
    regWrite(3'b010);
    check(regRdData == 4'b0010, "R2 program alone accepted", regRdData, 2);
    memWrite(16'h1234);
    check(busy == 1'b0 && pageBase == 16'h0, "R3 write with program select ignored", busy, 0);

    // R3 whole-array select blocks a page request
    regWrite(3'b101);
    memWrite(16'h2345);
    check(busy == 1'b0, "R3 write with whole-array select ignored", busy, 0);
    check(pageBase == 16'h0, "R3 page base unchanged", pageBase, 0);
    regWrite(3'b000);

    // R9 grant follows request when idle
    memRdReq = 1'b1;
    #1 check(memRdGrant == 1'b1, "R9 idle grant", memRdGrant, 1);
    memRdReq = 1'b0;
    #1 check(memRdGrant == 1'b0, "R9 idle no request", memRdGrant, 0);

    // directed runs
    runErase(16'h3C7F, 1'b0, 1'b0);
    runErase(16'hFFE7, 1'b0, 1'b0);   // R10 vector page
    runErase(16'hFFBF, 1'b1, 1'b0);   // R5 long mode, non-vector page
    runErase(16'h8040, 1'b0, 1'b1);   // R8 locked page
    regWrite(3'b001);
    check(errFlag == 1'b0, "R8 error cleared by register write", errFlag, 0);
    regWrite(3'b000);

    // random runs
    for (int i = 0; i < 10; i++) begin
      runErase(16'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule